// File: doc/BRIEF.md
# Three-Level Prioritized Interrupt Controller

This block chooses which of thirteen interrupt requests the processor core takes next. It then hands the core that source's fixed vector address. One source, power-fail, has a tier of its own above everything else. Each of the other twelve sources has a software bit that puts it in the high tier or the low tier. When several eligible requests share a tier, a fixed natural order decides between them: the lowest source number wins.

The controller keeps one in-service bit per tier, so services can nest up to three deep. A new request is granted only when its tier is strictly above every tier already in service. A return strobe from the core retires the highest active service. Arbitration is registered. On a grant the block raises a one-cycle acknowledge together with the source number and the vector, and the source number lets the peripheral clear an edge-type request.

Source numbering follows the natural order: 0 power-fail, 1 external 0, 2 timer 0, 3 external 1, 4 timer 1, 5 serial 0, 6 timer 2, 7 serial 1, 8 external 2, 9 external 3, 10 external 4, 11 external 5, 12 watchdog.

Top module: `irq_arb3`

## Requirements
- R1: While reset is asserted, and after it is released with no request, `ack` is 0, `ack_id` is 0, `vec` is 0 and `in_service` is 0.
- R2: Source k (1..12) is eligible only when `req[k]`, `src_en[k]` and `glob_en` are all 1. Power-fail (source 0) is eligible when `req[0]` and `src_en[0]` are 1, whatever the value of `glob_en`.
- R3: Power-fail always sits at the top tier, above every high-tier source. Its tier does not depend on `hi_sel`.
- R4: For source k in 1..12, `hi_sel[k-1]`=1 places it in the high tier and 0 places it in the low tier. An eligible high-tier source wins over any low-tier one.
- R5: Among eligible requests in the same tier, the one with the lowest source number is granted.
- R6: The vector for source 0 is 33h, for sources 1..6 it is 03h+8*(k-1), and for sources 7..12 it is 03h+8*k. So 03h..2Bh, then 3Bh..63h.
- R7: Requests are sampled at a rising clock edge. `ack`, `ack_id` and `vec` reflect a grant in the following cycle, and `ack` is high for exactly one cycle per grant.
- R8: A grant is made only when its tier is strictly higher than the highest set `in_service` bit. The grant sets that tier's bit (bit 0 low, bit 1 high, bit 2 power-fail). Same-tier and lower-tier requests wait.
- R9: A `reti` pulse clears the highest set `in_service` bit and leaves the register unchanged when it is empty. No grant is made in a cycle where `reti` is sampled high.
- R10: Up to three services nest: low, then high, then power-fail can all be in service together, and returns unwind them from the top down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 13 | Request flags, bit k = source k |
| src_en | input | 13 | Per-source enables, bit 0 = power-fail enable |
| glob_en | input | 1 | Global enable for sources 1..12 |
| hi_sel | input | 12 | Tier select, bit k-1 for source k (1 = high) |
| reti | input | 1 | Return-from-interrupt strobe |
| ack | output | 1 | One-cycle grant acknowledge |
| ack_id | output | 4 | Granted source number |
| vec | output | 8 | Granted vector address |
| in_service | output | 3 | In-service bits: [0] low, [1] high, [2] power-fail |

## Verification
The bench targets the nesting walk from low to high to power-fail and back, with a low-tier request waiting throughout. A design that allows same-tier preemption would acknowledge that waiting request too early. A design that grants in the return cycle would acknowledge it one cycle too soon. Power-fail is exercised with the global enable off and with every user source set to the high tier, which exposes a design that gates power-fail with the global enable or lets a user source tie with it. All thirteen vectors are checked one at a time, so an off-by-one around the gap at 33h would show up as a wrong address for sources 7 to 12.

// File: rtl/irq_arb3_pkg.sv
package irq_arb3_pkg;
  localparam int NSRC  = 13;
  localparam int NLVL  = 3;
  localparam int IDW   = $clog2(NSRC);
  localparam int LVW   = $clog2(NLVL);
  localparam int VECW  = 8;
  localparam int PF_ID = 0;
  localparam int GAP_AFTER = 6;   // sources above this skip the 33h slot

  typedef enum logic [LVW-1:0] {
    LVL_LOW  = 2'd0,
    LVL_HIGH = 2'd1,
    LVL_PF   = 2'd2
  } lvl_e;

  function automatic logic [VECW-1:0] vec_of(input logic [IDW-1:0] id);
    int slot;
    if (int'(id) == PF_ID) slot = GAP_AFTER;
    else if (int'(id) <= GAP_AFTER) slot = int'(id) - 1;
    else slot = int'(id);
    return VECW'(8'h03 + 8 * slot);
  endfunction
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N  = 13,
  parameter int IW = 4
) (
  input  logic [N-1:0]  reqs,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    hit = |reqs;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (reqs[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/irq_isr_track.sv
module irq_isr_track
  import irq_arb3_pkg::*;
#(
  parameter int L  = NLVL,
  parameter int LW = LVW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [LW-1:0] set_lvl,
  input  logic          ret,
  output logic [L-1:0]  isr,
  output logic          top_valid,
  output logic [LW-1:0] top_lvl
);
  logic [L-1:0] isr_q, isr_d;
  logic         isr_ce;

  always_comb begin
    top_valid = |isr_q;
    top_lvl   = '0;
    for (int i = 0; i < L; i++) begin
      if (isr_q[i]) top_lvl = LW'(i);
    end
  end

  always_comb begin
    isr_d  = isr_q;
    isr_ce = 1'b0;
    if (ret) begin
      isr_ce = top_valid;
      isr_d[top_lvl] = 1'b0;
    end else if (set_en) begin
      isr_ce = 1'b1;
      isr_d[set_lvl] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      isr_q <= '0;
    else if (isr_ce) isr_q <= isr_d;
  end

  assign isr = isr_q;

  AST_RET_CLEARS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && top_valid) |=> ($countones(isr_q) + 1 == $past($countones(isr_q)))); // R9
  AST_RET_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && !top_valid) |=> (isr_q == '0)); // R9
  AST_SET_ABOVE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && top_valid) |-> (set_lvl > top_lvl)); // R8
endmodule

// File: rtl/irq_arb3.sv
module irq_arb3
  import irq_arb3_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  req,
  input  logic [NSRC-1:0]  src_en,
  input  logic             glob_en,
  input  logic [NSRC-2:0]  hi_sel,
  input  logic             reti,
  output logic             ack,
  output logic [IDW-1:0]   ack_id,
  output logic [VECW-1:0]  vec,
  output logic [NLVL-1:0]  in_service
);
  logic [NSRC-1:0] elig;
  logic [NSRC-1:0] lvl_mask [NLVL];
  logic [NLVL-1:0] lvl_hit;
  logic [IDW-1:0]  lvl_idx  [NLVL];

  // eligibility and tier assignment per source
  for (genvar k = 0; k < NSRC; k++) begin : g_src
    if (k == PF_ID) begin : g_pf
      assign elig[k]             = req[k] & src_en[k];
      assign lvl_mask[LVL_PF][k]   = 1'b1;
      assign lvl_mask[LVL_HIGH][k] = 1'b0;
      assign lvl_mask[LVL_LOW][k]  = 1'b0;
    end else begin : g_usr
      assign elig[k]             = req[k] & src_en[k] & glob_en;
      assign lvl_mask[LVL_PF][k]   = 1'b0;
      assign lvl_mask[LVL_HIGH][k] = hi_sel[k-1];
      assign lvl_mask[LVL_LOW][k]  = ~hi_sel[k-1];
    end
  end

  // one fixed-order encoder per tier
  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    irq_prio_enc #(.N(NSRC), .IW(IDW)) u_enc (
      .reqs (elig & lvl_mask[g]),
      .hit  (lvl_hit[g]),
      .idx  (lvl_idx[g])
    );
  end

  logic           best_hit;
  logic [LVW-1:0] best_lvl;
  logic           top_valid;
  logic [LVW-1:0] top_lvl;
  logic           grant;

  always_comb begin
    best_hit = |lvl_hit;
    best_lvl = '0;
    for (int g = 0; g < NLVL; g++) begin
      if (lvl_hit[g]) best_lvl = LVW'(g);
    end
  end

  assign grant = best_hit && !reti && (!top_valid || (best_lvl > top_lvl));

  irq_isr_track #(.L(NLVL), .LW(LVW)) u_isr (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_en    (grant),
    .set_lvl   (best_lvl),
    .ret       (reti),
    .isr       (in_service),
    .top_valid (top_valid),
    .top_lvl   (top_lvl)
  );

  // grant registers
  logic            ack_q, ack_d;
  logic [IDW-1:0]  id_q, id_d;
  logic [VECW-1:0] vec_q, vec_d;
  logic [LVW-1:0]  lvl_q, lvl_d;
  logic            out_ce;

  always_comb begin
    ack_d  = grant;
    out_ce = grant;
    id_d   = lvl_idx[best_lvl];
    vec_d  = vec_of(lvl_idx[best_lvl]);
    lvl_d  = best_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= ack_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q  <= '0;
      vec_q <= '0;
      lvl_q <= '0;
    end else if (out_ce) begin
      id_q  <= id_d;
      vec_q <= vec_d;
      lvl_q <= lvl_d;
    end
  end

  assign ack    = ack_q;
  assign ack_id = id_q;
  assign vec    = vec_q;

  AST_ACK_MARKS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> in_service[lvl_q]); // R8
  AST_NO_GRANT_ON_RET: assert property (@(posedge clk) disable iff (!rst_n)
    reti |=> !ack); // R9
  AST_VEC_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (vec[2:0] == 3'b011)); // R6
  AST_PF_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && ack_id == IDW'(PF_ID)) |-> (lvl_q == LVL_PF)); // R3
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |-> (!ack && in_service == '0)); // R1
endmodule

// File: tb/tb_irq_arb3.sv
module tb_irq_arb3;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [12:0] req, src_en;
  logic        glob_en;
  logic [11:0] hi_sel;
  logic        reti;
  logic        ack;
  logic [3:0]  ack_id;
  logic [7:0]  vec;
  logic [2:0]  in_service;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  irq_arb3 dut (
    .clk(clk), .rst_n(rst_n), .req(req), .src_en(src_en), .glob_en(glob_en),
    .hi_sel(hi_sel), .reti(reti), .ack(ack), .ack_id(ack_id), .vec(vec),
    .in_service(in_service)
  );

  function automatic int exp_vec(input int k);
    case (k)
      0: return 'h33;  1: return 'h03;  2: return 'h0B;  3: return 'h13;
      4: return 'h1B;  5: return 'h23;  6: return 'h2B;  7: return 'h3B;
      8: return 'h43;  9: return 'h4B; 10: return 'h53; 11: return 'h5B;
      default: return 'h63;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reti();
    reti = 1'b1;
    step();
    reti = 1'b0;
  endtask

  task automatic chk_grant(input string tag, input int id, input int isr);
    chk({tag, " ack"}, int'(ack), 1);
    chk({tag, " id"}, int'(ack_id), id);
    chk({tag, " vec"}, int'(vec), exp_vec(id));
    chk({tag, " isr"}, int'(in_service), isr);
  endtask

  task automatic t_reset();
    chk("R1 ack", int'(ack), 0);
    chk("R1 id", int'(ack_id), 0);
    chk("R1 vec", int'(vec), 0);
    chk("R1 isr", int'(in_service), 0);
  endtask

  task automatic t_single();
    req = 13'h1 << 1;
    step();
    chk_grant("R7 single", 1, 3'b001);
    req = '0;
    step();
    chk("R7 one-cycle ack", int'(ack), 0);
    do_reti();
    chk("R9 return", int'(in_service), 0);
  endtask

  task automatic t_tie();
    req = (13'h1 << 3) | (13'h1 << 5);
    step();
    chk_grant("R5 tie", 3, 3'b001);
    req = '0;
    do_reti();
  endtask

  task automatic t_hilow();
    hi_sel = 12'h1 << 11;
    req = (13'h1 << 1) | (13'h1 << 12);
    step();
    chk_grant("R4 high wins", 12, 3'b010);
    req = 13'h1 << 1;
    step();
    chk("R8 lower waits", int'(ack), 0);
    do_reti();
    chk("R9 no grant on ret", int'(ack), 0);
    chk("R9 isr cleared", int'(in_service), 0);
    step();
    chk_grant("R8 low after ret", 1, 3'b001);
    req = '0;
    do_reti();
    hi_sel = '0;
  endtask

  task automatic t_enable();
    glob_en = 1'b0;
    req = 13'h1 << 2;
    step(); step();
    chk("R2 glob off ack", int'(ack), 0);
    chk("R2 glob off isr", int'(in_service), 0);
    req = 13'h1;
    step();
    chk_grant("R2 pf ignores glob", 0, 3'b100);
    req = '0;
    do_reti();
    glob_en = 1'b1;
    src_en = 13'h1FFF & ~(13'h1 << 9);
    req = 13'h1 << 9;
    step(); step();
    chk("R2 src off", int'(ack), 0);
    src_en = '0;
    req = 13'h1;
    step(); step();
    chk("R2 pf own enable", int'(ack), 0);
    src_en = 13'h1FFF;
    req = '0;
    step();
  endtask

  task automatic t_pf_top();
    hi_sel = 12'hFFF;
    req = 13'h3;
    step();
    chk_grant("R3 pf above high", 0, 3'b100);
    req = 13'h2;
    step();
    chk("R3 high below pf", int'(ack), 0);
    req = '0;
    do_reti();
    hi_sel = '0;
  endtask

  task automatic t_nest();
    req = 13'h1 << 6;
    step();
    chk_grant("R10 low", 6, 3'b001);
    req = 13'h1 << 7;
    step();
    chk("R8 same tier waits", int'(ack), 0);
    hi_sel = 12'h1 << 7;
    req = (13'h1 << 7) | (13'h1 << 8);
    step();
    chk_grant("R10 high nest", 8, 3'b011);
    req = (13'h1 << 7) | 13'h1;
    step();
    chk_grant("R10 pf nest", 0, 3'b111);
    req = 13'h1 << 7;
    do_reti();
    chk("R10 unwind1", int'(in_service), 3'b011);
    chk("R10 unwind1 ack", int'(ack), 0);
    do_reti();
    chk("R10 unwind2", int'(in_service), 3'b001);
    do_reti();
    chk("R10 unwind3", int'(in_service), 3'b000);
    chk("R9 ret cycle no ack", int'(ack), 0);
    step();
    chk_grant("R8 waiting low", 7, 3'b001);
    req = '0;
    do_reti();
    hi_sel = '0;
  endtask

  task automatic t_empty_reti();
    do_reti();
    chk("R9 empty ret", int'(in_service), 0);
  endtask

  task automatic t_vectors();
    for (int k = 0; k < 13; k++) begin
      req = 13'h1 << k;
      step();
      chk_grant("R6 vector", k, (k == 0) ? 3'b100 : 3'b001);
      req = '0;
      do_reti();
    end
  endtask

  initial begin
    rst_n = 1'b0; req = '0; src_en = 13'h1FFF; glob_en = 1'b1;
    hi_sel = '0; reti = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_single();
    t_tie();
    t_hilow();
    t_enable();
    t_pf_top();
    t_nest();
    t_empty_reti();
    t_vectors();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule